// File: doc/BRIEF.md
# Unsigned Magnitude Comparator with Independent Operand Widths

This block compares two unsigned operands, whose widths are set by separate parameters, and returns one bit. A two-bit relation select picks strictly-below, below-or-equal, strictly-above or above-or-equal. The output is combinational, so it is valid in the same cycle as its inputs.

The comparison does not use a built-in relational operator. The design zero-extends both operands to the wider of the two widths. It then walks a chain from the top bit downward. The chain carries a flag that says whether every bit above the current position matches. At each position a decision term fires when the two bits differ in the direction the relation asks for and all higher bits matched. The inclusive relations add one more term, the "all bits equal" flag at the bottom of the chain. The result is the OR of all terms. The block fits where a relation between fields of unequal size must be tested, such as a count against a threshold.

Top module: `mag_cmp_chain`

## Requirements
- R1: With rel = 2'b00, hit is 1 exactly when the value of opa is smaller than the value of opb.
- R2: With rel = 2'b01, hit is 1 exactly when opa is smaller than or equal to opb.
- R3: With rel = 2'b10, hit is 1 exactly when opa is larger than opb.
- R4: With rel = 2'b11, hit is 1 exactly when opa is larger than or equal to opb.
- R5: When WA exceeds WB, the missing upper bits of opb count as 0. Any set bit of opa above position WB-1 makes rel 2'b10 and 2'b11 give 1, and makes rel 2'b00 and 2'b01 give 0.
- R6: When WB exceeds WA, the missing upper bits of opa count as 0. Any set bit of opb above position WA-1 makes rel 2'b00 and 2'b01 give 1, and makes rel 2'b10 and 2'b11 give 0.
- R7: hit follows a change of opa, opb or rel with no clock edge in between.
- R8: When both operands have equal values, hit equals bit 0 of rel: 1 for the inclusive relations and 0 for the strict ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WA | First unsigned operand |
| opb | input | WB | Second unsigned operand |
| rel | input | 2 | Relation select: 00 below, 01 below-or-equal, 10 above, 11 above-or-equal |
| hit | output | 1 | 1 when opa stands in the selected relation to opb |

## Verification
The bound checker compares hit against the selected relation whenever an input changes. It also tests the equal-value rule and the effect of set upper bits on the wider operand. Exhaustive sweeps then cover every operand pair and every relation for three width pairs: 8 against 8, 8 against 4, and 4 against 8. The sweeps show that the results hold over the full input space and that hit follows a change within one clock period.

// File: rtl/mag_cmp_chain.sv
module mag_cmp_chain #(
  parameter int WA = 8,
  parameter int WB = 8
) (
  input  logic [WA-1:0] opa,
  input  logic [WB-1:0] opb,
  input  logic [1:0]    rel,
  output logic          hit
);
  localparam int W = (WA > WB) ? WA : WB;

  logic [W-1:0] xa, xb;
  logic [W:0]   same_above;
  logic [W:0]   term;
  logic         want_above, inclusive;

  assign want_above = rel[1];
  assign inclusive  = rel[0];

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_ext
      if (i < WA) begin : g_a
        assign xa[i] = opa[i];
      end else begin : g_az
        assign xa[i] = 1'b0;
      end
      if (i < WB) begin : g_b
        assign xb[i] = opb[i];
      end else begin : g_bz
        assign xb[i] = 1'b0;
      end
    end
  endgenerate

  assign same_above[W] = 1'b1;

  generate
    for (i = W - 1; i >= 0; i--) begin : g_chain
      logic differ_ok;
      assign differ_ok     = want_above ? (xa[i] & ~xb[i]) : (~xa[i] & xb[i]);
      assign term[i]       = differ_ok & same_above[i+1];
      assign same_above[i] = same_above[i+1] & ~(xa[i] ^ xb[i]);
    end
  endgenerate

  assign term[W] = inclusive & same_above[0];
  assign hit     = |term;
endmodule

// File: rtl/mag_cmp_chain_chk.sv
module mag_cmp_chain_chk #(
  parameter int WA = 8,
  parameter int WB = 8
) (
  input logic [WA-1:0] opa,
  input logic [WB-1:0] opb,
  input logic [1:0]    rel,
  input logic          hit
);
  localparam int W = (WA > WB) ? WA : WB;

  logic [W-1:0] va, vb;
  logic         known;

  assign va    = W'(opa);
  assign vb    = W'(opb);
  assign known = !$isunknown({opa, opb, rel, hit});

  always_comb begin
    if (known && rel == 2'b00) assert_below_R1: assert (hit == (va < vb));
    if (known && rel == 2'b01) assert_below_eq_R2: assert (hit == (va <= vb));
    if (known && rel == 2'b10) assert_above_R3: assert (hit == (va > vb));
    if (known && rel == 2'b11) assert_above_eq_R4: assert (hit == (va >= vb));
    if (known && va == vb) assert_equal_R8: assert (hit == rel[0]);
  end

  generate
    if (WA > WB) begin : g_a_wide
      always_comb begin
        if (known && |(opa >> WB)) assert_upper_a_R5: assert (hit == rel[1]);
      end
    end
    if (WB > WA) begin : g_b_wide
      always_comb begin
        if (known && |(opb >> WA)) assert_upper_b_R6: assert (hit == !rel[1]);
      end
    end
  endgenerate
endmodule

bind mag_cmp_chain mag_cmp_chain_chk #(.WA(WA), .WB(WB)) u_chk (
  .opa(opa), .opb(opb), .rel(rel), .hit(hit)
);

// File: tb/test_mag_cmp_chain.sv
module test_mag_cmp_chain;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  logic [7:0] a88, b88;
  logic [1:0] r88;
  logic       h88;
  logic [7:0] a84;
  logic [3:0] b84;
  logic [1:0] r84;
  logic       h84;
  logic [3:0] a48;
  logic [7:0] b48;
  logic [1:0] r48;
  logic       h48;

  mag_cmp_chain #(.WA(8), .WB(8)) i_mag_cmp_chain (.opa(a88), .opb(b88), .rel(r88), .hit(h88));
  mag_cmp_chain #(.WA(8), .WB(4)) i_mag_cmp_chain_ab (.opa(a84), .opb(b84), .rel(r84), .hit(h84));
  mag_cmp_chain #(.WA(4), .WB(8)) i_mag_cmp_chain_ba (.opa(a48), .opb(b48), .rel(r48), .hit(h48));

  function automatic logic ref_rel(int a, int b, int m);
    case (m)
      0: return a < b;
      1: return a <= b;
      2: return a > b;
      default: return a >= b;
    endcase
  endfunction

  function automatic string mode_tag(int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, int a, int b, int m, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s a=%0d b=%0d rel=%0d actual=%b expected=%b", tag, a, b, m, got, exp);
    end
  endtask

  task automatic t_start;
    a88 = 0; b88 = 0; r88 = 0;
    a84 = 0; b84 = 0; r84 = 0;
    a48 = 0; b48 = 0; r48 = 0;
    #1;
    chk("R1", 0, 0, 0, h88, 1'b0);
    chk("R1", 0, 0, 0, h84, 1'b0);
    chk("R1", 0, 0, 0, h48, 1'b0);
  endtask

  task automatic t_sweep_equal;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b++) begin
          a88 = 8'(a); b88 = 8'(b); r88 = 2'(m);
          #1;
          chk(mode_tag(m), a, b, m, h88, ref_rel(a, b, m));
        end
  endtask

  task automatic t_sweep_a_wide;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 16; b++) begin
          a84 = 8'(a); b84 = 4'(b); r84 = 2'(m);
          #1;
          chk((a > 15) ? "R5" : mode_tag(m), a, b, m, h84, ref_rel(a, b, m));
        end
  endtask

  task automatic t_sweep_b_wide;
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 256; b++) begin
          a48 = 4'(a); b48 = 8'(b); r48 = 2'(m);
          #1;
          chk((b > 15) ? "R6" : mode_tag(m), a, b, m, h48, ref_rel(a, b, m));
        end
  endtask

  task automatic t_corners;
    for (int m = 0; m < 4; m++) begin
      a88 = 8'hFF; b88 = 8'hFF; r88 = 2'(m);
      #1;
      chk("R8", 255, 255, m, h88, m[0]);
      a84 = 8'h10; b84 = 4'hF; r84 = 2'(m);
      #1;
      chk("R5", 16, 15, m, h84, m[1]);
      a48 = 4'hF; b48 = 8'h10; r48 = 2'(m);
      #1;
      chk("R6", 15, 16, m, h48, !m[1]);
    end
  endtask

  task automatic t_same_cycle;
    @(negedge clk);
    a88 = 8'd3; b88 = 8'd9; r88 = 2'b00;
    #0.5;
    chk("R7", 3, 9, 0, h88, 1'b1);
    r88 = 2'b10;
    #0.5;
    chk("R7", 3, 9, 2, h88, 1'b0);
    b88 = 8'd2;
    #0.5;
    chk("R7", 3, 2, 2, h88, 1'b1);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    t_start();
    t_corners();
    t_same_cycle();
    t_sweep_a_wide();
    t_sweep_b_wide();
    t_sweep_equal();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule